// File: doc/BRIEF.md
# Precision Time Offset Calculator

This block sits on the slave side of a two-way time transfer. It takes four event timestamps as strobed inputs, each with a sequence identifier:

- the slave's local receive time of a Sync;
- the master's send time of that Sync, which arrives either with the Sync or in a later Follow_up;
- the slave's local send time of a Delay_Req;
- the master's receive time of that Delay_Req, returned in a Delay_Resp.

From these it derives the mean path delay, the clock offset (slave time minus master time) and the drift over each Sync interval. Each of the three results is published as a signed nanosecond value with a single-cycle valid pulse.

A mode input selects how the master send time is delivered. In one-step delivery it comes with the Sync itself. In two-step delivery it follows in a separate message, and the block joins it to the local receive time it has held for the Sync with the same sequence identifier. A late message that does not belong to the pending event is thrown away and flagged.

Message parsing, timestamp capture and the clock servo sit outside the block. The servo consumes the results.

Top module: `ptp_offset_calc`

## Requirements
- R1: After reset, `path_vld`, `drift_vld` and `seq_mismatch` are low, and `path_delay`, `clk_offset` and `drift_ns` are zero.
- R2: Values are 64-bit two's-complement nanoseconds. With A = t1 - t0 and B = t3 - t2, `path_delay` is (A + B) arithmetically shifted right by one and `clk_offset` is (A - B) arithmetically shifted right by one. The shift rounds toward minus infinity, so A - B = -399 gives -200.
- R3: With `two_step` = 0, a `sync_stb` completes a Sync pair at once, taking t1 from `sync_rx_ts` and t0 from `sync_tx_ts`.
- R4: With `two_step` = 1, a `sync_stb` only stores t1 and its sequence identifier, and `sync_tx_ts` is ignored. A later `fup_stb` with an equal `fup_seq` completes the pair, with t0 taken from `fup_tx_ts`.
- R5: A `fup_stb` or `dresp_stb` is discarded if no event is pending or if its sequence identifier differs from the pending one. The discard raises `seq_mismatch` for one cycle, in the cycle after the strobe, and the pending event stays pending.
- R6: `path_vld` pulses for one cycle in the cycle after the strobe that completes the last of the four timestamps of an exchange. `path_delay` and `clk_offset` change only with that pulse and hold their values otherwise.
- R7: An exchange pairs the newest completed Sync pair with the newest completed delay pair, and both are consumed by the output. The next output needs a new pair of each kind.
- R8: `drift_vld` pulses in the cycle after each Sync pair completes, starting with the second Sync pair since reset. `drift_ns` = (t1[k+1] - t1[k]) - (t0[k+1] - t0[k]), and it holds its value between pulses.
- R9: A new `sync_stb` (two-step) or `dreq_stb` that arrives while a join is pending replaces the pending event.
- R10: A delay pair that completes before its Sync pair is held. The output then follows the completion of the Sync pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| two_step | input | 1 | 1: master send time comes in a Follow_up |
| sync_stb | input | 1 | Sync event strobe |
| sync_seq | input | 16 | Sync sequence identifier |
| sync_rx_ts | input | 64 | Local Sync receive time t1 |
| sync_tx_ts | input | 64 | Master Sync send time t0 (one-step only) |
| fup_stb | input | 1 | Follow_up strobe |
| fup_seq | input | 16 | Follow_up sequence identifier |
| fup_tx_ts | input | 64 | Master Sync send time t0 (two-step) |
| dreq_stb | input | 1 | Delay_Req send strobe |
| dreq_seq | input | 16 | Delay_Req sequence identifier |
| dreq_tx_ts | input | 64 | Local Delay_Req send time t2 |
| dresp_stb | input | 1 | Delay_Resp strobe |
| dresp_seq | input | 16 | Delay_Resp sequence identifier |
| dresp_rx_ts | input | 64 | Master receive time t3 |
| path_vld | output | 1 | Delay and offset valid pulse |
| path_delay | output | 64 | Mean path delay, signed ns |
| clk_offset | output | 64 | Slave minus master offset, signed ns |
| drift_vld | output | 1 | Drift valid pulse |
| drift_ns | output | 64 | Drift over one Sync interval, signed ns |
| seq_mismatch | output | 1 | Discarded late message pulse |

## Verification
Delay and offset, drift, and the mismatch flag all appear exactly one cycle after the clock edge that samples the completing or offending strobe.

Each driver task records that due cycle as it raises a strobe. The expected item pushed to the scoreboard carries the due cycle, and the monitor compares both the value and the cycle counter when the valid pulse shows up. Any pulse that arrives with nothing queued is counted as a failure, as is any expected item still queued at the end of the run. Together these catch early, late, missing and spurious results.

// File: rtl/ptp_calc_pkg.sv
// Package: shared widths and the exchange state type of the offset calculator.
// Assumes timestamps are free-running nanosecond counts that fit in TS_W bits.
package ptp_calc_pkg;
    localparam int TS_W_DEF  = 64;
    localparam int SEQ_W_DEF = 16;

    // Which half of an exchange is held while the other is awaited.
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_HAVE_A = 2'd1,
        XS_HAVE_B = 2'd2
    } xchg_state_t;
endpackage

// File: rtl/ptp_ts_joiner.sv
// Module: joins a locally captured timestamp with the remote one that belongs
// to the same event.
// - In immediate mode, the capture strobe carries both timestamps and the pair
//   completes on that strobe.
// - Otherwise the local timestamp waits, keyed by its sequence identifier,
//   until a join strobe with the same identifier arrives.
// - A join strobe with no pending event, or with a different identifier, is
//   rejected and leaves the pending event alone.
// Assumes: outputs are combinational and valid only in the strobe cycle.
module ptp_ts_joiner #(
    parameter int TS_W  = 64,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imm_mode,
    input  logic             cap_stb,
    input  logic [SEQ_W-1:0] cap_seq,
    input  logic [TS_W-1:0]  cap_local_ts,
    input  logic [TS_W-1:0]  cap_remote_ts,
    input  logic             join_stb,
    input  logic [SEQ_W-1:0] join_seq,
    input  logic [TS_W-1:0]  join_remote_ts,
    output logic             pair_done,
    output logic [TS_W-1:0]  pair_local_ts,
    output logic [TS_W-1:0]  pair_remote_ts,
    output logic             join_reject
);
    logic             pend_q;
    logic [SEQ_W-1:0] seq_q;
    logic [TS_W-1:0]  loc_q;
    logic             join_hit;
    logic             imm_hit;

    // Decide whether this cycle completes a pair, and from which sources.
    always_comb begin
        join_hit    = join_stb && pend_q && (join_seq == seq_q);
        imm_hit     = cap_stb && imm_mode;
        pair_done   = join_hit || imm_hit;
        join_reject = join_stb && !join_hit;
        if (imm_hit) begin
            pair_local_ts  = cap_local_ts;
            pair_remote_ts = cap_remote_ts;
        end else begin
            pair_local_ts  = loc_q;
            pair_remote_ts = join_remote_ts;
        end
    end

    // Hold the pending local timestamp; a new capture replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            seq_q  <= '0;
            loc_q  <= '0;
        end else if (cap_stb && !imm_mode) begin
            pend_q <= 1'b1;
            seq_q  <= cap_seq;
            loc_q  <= cap_local_ts;
        end else if (join_hit || imm_hit) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ptp_drift_calc.sv
// Module: drift over one Sync interval, from consecutive completed Sync pairs.
// Assumes: pair_done marks a completed (t0, t1) pair. The first pair after
// reset only seeds the history and produces no output.
module ptp_drift_calc #(
    parameter int TS_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pair_done,
    input  logic [TS_W-1:0]        t0_ts,
    input  logic [TS_W-1:0]        t1_ts,
    output logic                   drift_vld,
    output logic signed [TS_W-1:0] drift_ns
);
    logic                   have_prev_q;
    logic [TS_W-1:0]        prev_t0_q;
    logic [TS_W-1:0]        prev_t1_q;
    logic signed [TS_W-1:0] d_slave;
    logic signed [TS_W-1:0] d_master;

    // Elapsed time on each side since the previous pair.
    always_comb begin
        d_slave  = $signed(t1_ts - prev_t1_q);
        d_master = $signed(t0_ts - prev_t0_q);
    end

    // Update the history and publish drift from the second pair onward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_t0_q   <= '0;
            prev_t1_q   <= '0;
            drift_vld   <= 1'b0;
            drift_ns    <= '0;
        end else begin
            drift_vld <= pair_done && have_prev_q;
            if (pair_done) begin
                have_prev_q <= 1'b1;
                prev_t0_q   <= t0_ts;
                prev_t1_q   <= t1_ts;
                if (have_prev_q) begin
                    drift_ns <= d_slave - d_master;
                end
            end
        end
    end
endmodule

// File: rtl/ptp_offset_calc.sv
// Module: slave-side delay, offset and drift calculator.
// - Joins Sync send/receive times (one-step or two-step) and Delay_Req
//   send/receive times.
// - A three-state machine pairs the newest of each and publishes
//   delay = (A+B)>>>1 and offset = (A-B)>>>1 one cycle after the completing
//   strobe.
// Assumes: sync_tx_ts is meaningful only when two_step is low.
module ptp_offset_calc
    import ptp_calc_pkg::*;
#(
    parameter int TS_W  = TS_W_DEF,
    parameter int SEQ_W = SEQ_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   two_step,
    input  logic                   sync_stb,
    input  logic [SEQ_W-1:0]       sync_seq,
    input  logic [TS_W-1:0]        sync_rx_ts,
    input  logic [TS_W-1:0]        sync_tx_ts,
    input  logic                   fup_stb,
    input  logic [SEQ_W-1:0]       fup_seq,
    input  logic [TS_W-1:0]        fup_tx_ts,
    input  logic                   dreq_stb,
    input  logic [SEQ_W-1:0]       dreq_seq,
    input  logic [TS_W-1:0]        dreq_tx_ts,
    input  logic                   dresp_stb,
    input  logic [SEQ_W-1:0]       dresp_seq,
    input  logic [TS_W-1:0]        dresp_rx_ts,
    output logic                   path_vld,
    output logic signed [TS_W-1:0] path_delay,
    output logic signed [TS_W-1:0] clk_offset,
    output logic                   drift_vld,
    output logic signed [TS_W-1:0] drift_ns,
    output logic                   seq_mismatch
);
    logic                   s_done, d_done;
    logic [TS_W-1:0]        s_t1, s_t0, d_t2, d_t3;
    logic                   s_rej, d_rej;
    xchg_state_t            st_q, st_d;
    logic signed [TS_W-1:0] a_q, b_q, a_cur, b_cur, sum_ab, dif_ab;
    logic                   emit;

    // Sync pair: local receive time t1 joined with master send time t0.
    ptp_ts_joiner #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_sync_join (
        .clk            (clk),
        .rst_n          (rst_n),
        .imm_mode       (!two_step),
        .cap_stb        (sync_stb),
        .cap_seq        (sync_seq),
        .cap_local_ts   (sync_rx_ts),
        .cap_remote_ts  (sync_tx_ts),
        .join_stb       (fup_stb),
        .join_seq       (fup_seq),
        .join_remote_ts (fup_tx_ts),
        .pair_done      (s_done),
        .pair_local_ts  (s_t1),
        .pair_remote_ts (s_t0),
        .join_reject    (s_rej)
    );

    // Delay pair: local send time t2 joined with master receive time t3.
    ptp_ts_joiner #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_dly_join (
        .clk            (clk),
        .rst_n          (rst_n),
        .imm_mode       (1'b0),
        .cap_stb        (dreq_stb),
        .cap_seq        (dreq_seq),
        .cap_local_ts   (dreq_tx_ts),
        .cap_remote_ts  ({TS_W{1'b0}}),
        .join_stb       (dresp_stb),
        .join_seq       (dresp_seq),
        .join_remote_ts (dresp_rx_ts),
        .pair_done      (d_done),
        .pair_local_ts  (d_t2),
        .pair_remote_ts (d_t3),
        .join_reject    (d_rej)
    );

    // Drift between consecutive Sync pairs.
    ptp_drift_calc #(.TS_W(TS_W)) u_drift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_done (s_done),
        .t0_ts     (s_t0),
        .t1_ts     (s_t1),
        .drift_vld (drift_vld),
        .drift_ns  (drift_ns)
    );

    // Current A and B terms, and the exchange state machine's next state.
    always_comb begin
        a_cur  = s_done ? $signed(s_t1 - s_t0) : a_q;
        b_cur  = d_done ? $signed(d_t3 - d_t2) : b_q;
        sum_ab = a_cur + b_cur;
        dif_ab = a_cur - b_cur;
        emit   = (s_done && (d_done || st_q == XS_HAVE_B)) ||
                 (d_done && st_q == XS_HAVE_A);
        st_d   = st_q;
        if (emit) begin
            st_d = XS_IDLE;
        end else if (s_done) begin
            st_d = XS_HAVE_A;
        end else if (d_done) begin
            st_d = XS_HAVE_B;
        end
    end

    // Hold partial terms, advance the state, register the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= XS_IDLE;
            a_q          <= '0;
            b_q          <= '0;
            path_vld     <= 1'b0;
            path_delay   <= '0;
            clk_offset   <= '0;
            seq_mismatch <= 1'b0;
        end else begin
            st_q         <= st_d;
            path_vld     <= emit;
            seq_mismatch <= s_rej || d_rej;
            if (s_done) begin
                a_q <= a_cur;
            end
            if (d_done) begin
                b_q <= b_cur;
            end
            if (emit) begin
                path_delay <= sum_ab >>> 1;
                clk_offset <= dif_ab >>> 1;
            end
        end
    end
endmodule

// File: rtl/ptp_offset_calc_chk.sv
// Checker: port-level timing properties of the offset calculator.
// Assumes: bound to every instance of ptp_offset_calc.
module ptp_offset_calc_chk #(
    parameter int TS_W = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sync_stb,
    input logic                   fup_stb,
    input logic                   dresp_stb,
    input logic                   path_vld,
    input logic signed [TS_W-1:0] path_delay,
    input logic signed [TS_W-1:0] clk_offset,
    input logic                   drift_vld,
    input logic signed [TS_W-1:0] drift_ns,
    input logic                   seq_mismatch
);
    // R5
    mismatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_mismatch |-> $past(fup_stb || dresp_stb));

    // R6
    path_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_vld |-> $past(sync_stb || fup_stb || dresp_stb));

    // R6
    path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !path_vld |-> ($stable(path_delay) && $stable(clk_offset)));

    // R8
    drift_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drift_vld |-> $past(sync_stb || fup_stb));

    // R8
    drift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drift_vld |-> $stable(drift_ns));
endmodule

bind ptp_offset_calc ptp_offset_calc_chk #(.TS_W(TS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_stb     (sync_stb),
    .fup_stb      (fup_stb),
    .dresp_stb    (dresp_stb),
    .path_vld     (path_vld),
    .path_delay   (path_delay),
    .clk_offset   (clk_offset),
    .drift_vld    (drift_vld),
    .drift_ns     (drift_ns),
    .seq_mismatch (seq_mismatch)
);

// File: tb/ptp_offset_calc_tb.sv
`timescale 1ns/100ps
module ptp_offset_calc_tb;
    typedef struct {
        longint v1;
        longint v2;
        int     due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        two_step = 1'b0;
    logic        sync_stb = 1'b0, fup_stb = 1'b0, dreq_stb = 1'b0, dresp_stb = 1'b0;
    logic [15:0] sync_seq = '0, fup_seq = '0, dreq_seq = '0, dresp_seq = '0;
    logic [63:0] sync_rx_ts = '0, sync_tx_ts = '0, fup_tx_ts = '0;
    logic [63:0] dreq_tx_ts = '0, dresp_rx_ts = '0;
    logic        path_vld, drift_vld, seq_mismatch;
    logic signed [63:0] path_delay, clk_offset, drift_ns;

    int   cyc = 0;
    int   last_due = 0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t q_path[$];
    exp_t q_drift[$];
    int   q_mm[$];
    exp_t item;

    ptp_offset_calc u_dut (
        .clk(clk), .rst_n(rst_n), .two_step(two_step),
        .sync_stb(sync_stb), .sync_seq(sync_seq), .sync_rx_ts(sync_rx_ts), .sync_tx_ts(sync_tx_ts),
        .fup_stb(fup_stb), .fup_seq(fup_seq), .fup_tx_ts(fup_tx_ts),
        .dreq_stb(dreq_stb), .dreq_seq(dreq_seq), .dreq_tx_ts(dreq_tx_ts),
        .dresp_stb(dresp_stb), .dresp_seq(dresp_seq), .dresp_rx_ts(dresp_rx_ts),
        .path_vld(path_vld), .path_delay(path_delay), .clk_offset(clk_offset),
        .drift_vld(drift_vld), .drift_ns(drift_ns), .seq_mismatch(seq_mismatch)
    );

    // 200 MHz clock and a cycle counter.
    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver tasks: one-cycle strobe; last_due is the cycle its result is due.
    task automatic do_sync(input int seq, input longint t1, input longint t0);
        @(posedge clk); #1;
        sync_stb = 1'b1; sync_seq = 16'(seq); sync_rx_ts = t1; sync_tx_ts = t0;
        last_due = cyc + 1;
        @(posedge clk); #1;
        sync_stb = 1'b0;
    endtask

    task automatic do_fup(input int seq, input longint t0);
        @(posedge clk); #1;
        fup_stb = 1'b1; fup_seq = 16'(seq); fup_tx_ts = t0;
        last_due = cyc + 1;
        @(posedge clk); #1;
        fup_stb = 1'b0;
    endtask

    task automatic do_dreq(input int seq, input longint t2);
        @(posedge clk); #1;
        dreq_stb = 1'b1; dreq_seq = 16'(seq); dreq_tx_ts = t2;
        last_due = cyc + 1;
        @(posedge clk); #1;
        dreq_stb = 1'b0;
    endtask

    task automatic do_dresp(input int seq, input longint t3);
        @(posedge clk); #1;
        dresp_stb = 1'b1; dresp_seq = 16'(seq); dresp_rx_ts = t3;
        last_due = cyc + 1;
        @(posedge clk); #1;
        dresp_stb = 1'b0;
    endtask

    // Scoreboard pushes, computed from the requirement formulas.
    task automatic exp_path(input longint a, input longint b);
        q_path.push_back('{(a + b) >>> 1, (a - b) >>> 1, last_due});
    endtask

    task automatic exp_drift(input longint d);
        q_drift.push_back('{d, 0, last_due});
    endtask

    task automatic exp_mm();
        q_mm.push_back(last_due);
    endtask

    // Monitor: compare each result pulse with the head of its queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (path_vld) begin
                if (q_path.size() == 0) begin
                    chk(1'b0, "R6", "unexpected path_vld", 1, 0);
                end else begin
                    item = q_path.pop_front();
                    chk(cyc == item.due, "R6", "path cycle", cyc, item.due);
                    chk(path_delay == item.v1, "R2", "path_delay", path_delay, item.v1);
                    chk(clk_offset == item.v2, "R2", "clk_offset", clk_offset, item.v2);
                end
            end
            if (drift_vld) begin
                if (q_drift.size() == 0) begin
                    chk(1'b0, "R8", "unexpected drift_vld", 1, 0);
                end else begin
                    item = q_drift.pop_front();
                    chk(cyc == item.due, "R8", "drift cycle", cyc, item.due);
                    chk(drift_ns == item.v1, "R8", "drift_ns", drift_ns, item.v1);
                end
            end
            if (seq_mismatch) begin
                if (q_mm.size() == 0) begin
                    chk(1'b0, "R5", "unexpected seq_mismatch", 1, 0);
                end else begin
                    chk(cyc == q_mm[0], "R5", "mismatch cycle", cyc, q_mm[0]);
                    void'(q_mm.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(path_vld == 1'b0, "R1", "path_vld", path_vld, 0);
        chk(drift_vld == 1'b0, "R1", "drift_vld", drift_vld, 0);
        chk(seq_mismatch == 1'b0, "R1", "seq_mismatch", seq_mismatch, 0);
        chk(path_delay == 0, "R1", "path_delay", path_delay, 0);
        chk(clk_offset == 0, "R1", "clk_offset", clk_offset, 0);
        chk(drift_ns == 0, "R1", "drift_ns", drift_ns, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R3 one-step exchange; first Sync pair seeds drift only (R8).
        do_sync(1, 1600, 1000);
        do_dreq(1, 2000);
        do_dresp(1, 2400); exp_path(600, 400);
        // Second Sync pair yields the first drift.
        do_sync(2, 11610, 11000); exp_drift(10);
        do_dreq(2, 12000);
        do_dresp(2, 12390); exp_path(610, 390);
        // R2 negative offset with odd difference: floor rounding.
        do_sync(3, 21301, 21000); exp_drift(-309);
        do_dreq(3, 22000);
        do_dresp(3, 22700); exp_path(301, 700);

        // R4 two-step: sync_tx_ts ignored; R5 wrong Follow_up discarded.
        two_step = 1'b1;
        do_sync(10, 31700, 999999);
        do_fup(11, 5); exp_mm();
        do_fup(10, 31000); exp_drift(399);
        // R5 Delay_Resp with nothing pending.
        do_dresp(5, 100); exp_mm();
        // R9 second Delay_Req replaces the first.
        do_dreq(7, 32000);
        do_dreq(8, 32100);
        do_dresp(7, 32400); exp_mm();
        do_dresp(8, 32500); exp_path(700, 400);

        // R10 delay pair first, Sync pair completes the exchange.
        do_dreq(9, 40000);
        do_dresp(9, 40200);
        do_sync(11, 41500, 0);
        do_fup(11, 41000); exp_path(500, 200); exp_drift(-200);

        // R7 exchange consumed: a lone delay pair gives no output.
        do_dreq(12, 50000);
        do_dresp(12, 50300);

        repeat (6) @(negedge clk);
        chk(q_path.size() == 0, "R7", "pending path results", q_path.size(), 0);
        chk(q_drift.size() == 0, "R8", "pending drift results", q_drift.size(), 0);
        chk(q_mm.size() == 0, "R5", "pending mismatch pulses", q_mm.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule